// File: doc/BRIEF.md
# Quadword DMA Channel Engine

This block is one memory-to-peripheral DMA channel. Software programs it through a narrow register write port. It takes a source byte address, a length counted in 128-bit quadwords, and a control word. Writing the start value to the control word launches a bounded burst. The engine fetches the quadwords from memory one at a time and hands each one to a downstream consumer over a valid/ready stream. It flags the final beat, so a downstream gate can key on the end of the burst. When the burst finishes, the engine raises a single-cycle completion pulse.

The engine keeps at most one memory read in flight. Each read is a one-cycle request with an address. The memory answers later with a one-cycle read-valid strobe and the data.

The output stream follows the usual back-pressure rules. Once `out_valid` is high, it stays high with `out_data` and `out_last` unchanged until `out_ready` is sampled high at a clock edge. A beat is transferred on every edge where both `out_valid` and `out_ready` are high. `out_ready` may be high or low at any time, and the engine never waits for `out_ready` before raising `out_valid`. The next memory read is issued only after the current beat has been taken.

Top module: `qdma_channel`

## Requirements
- R1: A register write at offset 0x10 loads the source byte address. A write at offset 0x20 loads the quadword count from the low bits of the write data. A write of exactly 0x1 to offset 0x00 while idle starts a transfer. Any other value written to offset 0x00 starts nothing.
- R2: For a count N > 0, the engine reads addresses src, src+16, ..., src+16*(N-1) in that order, with 32-bit wrap-around. Each returned 128-bit word appears unchanged as one stream beat, in the same order.
- R3: `mem_req` lasts one cycle per read. No new request is issued while a read is outstanding or while a beat waits on the stream. Exactly N requests are made for a count of N.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R5: `out_last` is high only on the beat carrying the final quadword.
- R6: Each started transfer produces exactly one `done_pulse`, one cycle wide. It appears in the cycle after the final beat is accepted, and by then `chan_busy` is already low.
- R7: A start with a count of 0 issues no request and produces no beat. `chan_busy` stays low, and `done_pulse` is high in the cycle after the start write.
- R8: While `chan_busy` is high, writes to the address, the count and the control word are ignored. The running transfer continues with its original settings.
- R9: Reset, asserted low, clears `chan_busy`, `out_valid`, `mem_req` and `done_pulse`, including in the middle of a transfer.
- R10: `chan_busy` rises in the cycle after an accepted start with a nonzero count, and stays high until the completion edge. `mem_req` is high only while `chan_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_off | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Byte address of the read |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | 128 | Read data quadword |
| out_valid | output | 1 | Stream beat valid |
| out_data | output | 128 | Stream beat data |
| out_last | output | 1 | Final beat of the burst |
| out_ready | input | 1 | Downstream can accept the beat |
| chan_busy | output | 1 | Transfer in progress (start bit) |
| done_pulse | output | 1 | One-cycle completion pulse |

## Verification
The bound assertions check four things on every cycle:
- `mem_req` is a single-cycle strobe that never coincides with a pending beat.
- An offered beat holds steady under back-pressure.
- Acceptance of a last beat is followed by the completion pulse.
- That pulse is isolated and comes with the channel idle.

Only the bench scenarios can show the rest: the address sequence and data order, the exact request and beat counts, the zero-length start, the writes ignored while busy, and the effect of reset in the middle of a burst.

// File: rtl/qdma_pkg.sv
package qdma_pkg;
  localparam logic [7:0]  OFF_CTRL  = 8'h00;
  localparam logic [7:0]  OFF_SRC   = 8'h10;
  localparam logic [7:0]  OFF_LEN   = 8'h20;
  localparam logic [31:0] CTRL_GO   = 32'h0000_0001;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_SEND = 2'd3
  } chan_state_e;
endpackage

// File: rtl/qdma_regs.sv
module qdma_regs
  import qdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int WD_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_off,
  input  logic [WD_W-1:0]   wr_data,
  input  logic              busy,
  output logic [ADDR_W-1:0] src_addr,
  output logic [CNT_W-1:0]  qw_count,
  output logic              start_req
);
  logic wr_ok;
  assign wr_ok = wr_en && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_addr <= '0;
      qw_count <= '0;
    end else if (wr_ok) begin
      if (wr_off == OFF_SRC) src_addr <= wr_data[ADDR_W-1:0];
      if (wr_off == OFF_LEN) qw_count <= wr_data[CNT_W-1:0];
    end
  end

  assign start_req = wr_ok && (wr_off == OFF_CTRL) && (wr_data == WD_W'(CTRL_GO));
endmodule

// File: rtl/qdma_seq.sv
module qdma_seq
  import qdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [CNT_W-1:0]  qw_count,
  input  logic              mem_rvalid,
  input  logic              beat_taken,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              load_beat,
  output logic              load_last,
  output logic              busy,
  output logic              done_pulse
);
  localparam int BEAT_BYTES = DATA_W / 8;

  chan_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_req) begin
            if (qw_count == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q <= ST_REQ;
              addr_q  <= src_addr;
              rem_q   <= qw_count;
            end
          end
        end
        ST_REQ:  state_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid) state_q <= ST_SEND;
        ST_SEND: begin
          if (beat_taken) begin
            if (rem_q == CNT_W'(1)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_REQ;
              rem_q   <= rem_q - CNT_W'(1);
              addr_q  <= addr_q + ADDR_W'(BEAT_BYTES);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req    = (state_q == ST_REQ);
  assign mem_addr   = addr_q;
  assign load_beat  = (state_q == ST_WAIT) && mem_rvalid;
  assign load_last  = (rem_q == CNT_W'(1));
  assign busy       = (state_q != ST_IDLE);
  assign done_pulse = done_q;
endmodule

// File: rtl/qdma_out_stage.sv
module qdma_out_stage #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_last,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              taken
);
  logic              vld_q;
  logic              lst_q;
  logic [DATA_W-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      lst_q <= 1'b0;
      dat_q <= '0;
    end else if (load) begin
      vld_q <= 1'b1;
      lst_q <= load_last;
      dat_q <= load_data;
    end else if (taken) begin
      vld_q <= 1'b0;
    end
  end

  assign taken     = vld_q && out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign out_last  = vld_q && lst_q;
endmodule

// File: rtl/qdma_channel.sv
module qdma_channel #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_off,
  input  logic [31:0]       cfg_wdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  input  logic              out_ready,
  output logic              chan_busy,
  output logic              done_pulse
);
  logic [ADDR_W-1:0] src_addr;
  logic [CNT_W-1:0]  qw_count;
  logic              start_req;
  logic              load_beat;
  logic              load_last;
  logic              beat_taken;

  qdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WD_W(32)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_off    (cfg_off),
    .wr_data   (cfg_wdata),
    .busy      (chan_busy),
    .src_addr  (src_addr),
    .qw_count  (qw_count),
    .start_req (start_req)
  );

  qdma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .src_addr   (src_addr),
    .qw_count   (qw_count),
    .mem_rvalid (mem_rvalid),
    .beat_taken (beat_taken),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .load_beat  (load_beat),
    .load_last  (load_last),
    .busy       (chan_busy),
    .done_pulse (done_pulse)
  );

  qdma_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_beat),
    .load_data (mem_rdata),
    .load_last (load_last),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .taken     (beat_taken)
  );
endmodule

// File: rtl/qdma_channel_chk.sv
module qdma_channel_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_last,
  input logic [DATA_W-1:0] out_data,
  input logic              chan_busy,
  input logic              done_pulse
);
  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R3

  AST_NO_REQ_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !out_valid); // R3

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R4

  AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> done_pulse); // R6

  AST_DONE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (!chan_busy && !out_valid)); // R6

  AST_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> chan_busy); // R10
endmodule

bind qdma_channel qdma_channel_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_last   (out_last),
  .out_data   (out_data),
  .chan_busy  (chan_busy),
  .done_pulse (done_pulse)
);

// File: tb/qdma_channel_tb.sv
`timescale 1ns/1ps
module qdma_channel_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_wr_en;
  logic [7:0]   cfg_off;
  logic [31:0]  cfg_wdata;
  logic         mem_req;
  logic [31:0]  mem_addr;
  logic         mem_rvalid;
  logic [127:0] mem_rdata;
  logic         out_valid;
  logic [127:0] out_data;
  logic         out_last;
  logic         out_ready;
  logic         chan_busy;
  logic         done_pulse;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  qdma_channel u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .chan_busy(chan_busy), .done_pulse(done_pulse)
  );

  function automatic logic [127:0] word_at(input logic [31:0] a);
    return {a ^ 32'h5A5A_0000, ~a, a + 32'h1357_9BDF, a};
  endfunction

  // memory model: answers one cycle after each request
  initial mem_rvalid = 1'b0;
  initial mem_rdata  = '0;
  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= word_at(mem_addr);
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_off = off; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_off = '0; cfg_wdata = '0;
  endtask

  function automatic logic ready_of(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return cyc[0];
      default: return (cyc % 3) == 2;
    endcase
  endfunction

  // Runs from a negedge; samples 1 ns after each negedge.
  task automatic run_xfer(input logic [31:0] base, input int cnt, input int mode,
                          input int exp_reqs, input string tag);
    int beats = 0, reqs = 0, dones = 0, cyc = 0, after = 0;
    bit hold = 0, hold_bad = 0, last_bad = 0, data_bad = 0;
    logic [127:0] hdata = '0, bad_act = '0, bad_exp = '0;
    logic hlast = 1'b0;
    while (after < 4 && cyc < 3000) begin
      out_ready = ready_of(mode, cyc);
      #1;
      if (mem_req) reqs++;
      if (hold && (!out_valid || out_data !== hdata || out_last !== hlast)) hold_bad = 1;
      if (out_valid && out_ready) begin
        if (out_data !== word_at(base + 32'(beats) * 32'd16) && !data_bad) begin
          data_bad = 1; bad_act = out_data; bad_exp = word_at(base + 32'(beats) * 32'd16);
        end
        if (out_last !== (beats == cnt - 1)) last_bad = 1;
        beats++;
      end
      hold  = out_valid && !out_ready;
      hdata = out_data;
      hlast = out_last;
      if (done_pulse) begin
        dones++;
        if (chan_busy) last_bad = 1;
      end
      if (dones > 0) after++;
      cyc++;
      @(negedge clk);
    end
    check(!data_bad, {tag, " R2 beat data/address order"}, bad_act, bad_exp);
    check(beats == cnt, {tag, " R2 beat count"}, 128'(beats), 128'(cnt));
    check(reqs == exp_reqs, {tag, " R3 request count"}, 128'(reqs), 128'(exp_reqs));
    check(!hold_bad, {tag, " R4 beat held under back-pressure"}, 128'(hold_bad), 128'd0);
    check(!last_bad, {tag, " R5 last only on final beat"}, 128'(last_bad), 128'd0);
    check(dones == 1 && !chan_busy, {tag, " R6 single done, idle after"}, 128'(dones), 128'd1);
    out_ready = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] cnt;
    logic [1:0]  mode;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0500, 16'd4, 2'd0},
    '{32'h0000_1000, 16'd1, 2'd1},
    '{32'h0000_FFF0, 16'd3, 2'd2},
    '{32'h0000_0020, 16'd7, 2'd1},
    '{32'hFFFF_FFF0, 16'd2, 2'd0},
    '{32'h0000_0003, 16'd5, 2'd2}
  };

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_off = '0; cfg_wdata = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!chan_busy && !out_valid && !mem_req && !done_pulse, "R9 reset state",
          {chan_busy, out_valid, mem_req, done_pulse}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    // table of transfers
    for (int v = 0; v < 6; v++) begin
      cfg_write(8'h10, VECS[v].base);
      cfg_write(8'h20, 32'(VECS[v].cnt));
      cfg_write(8'h00, 32'h1);
      check(chan_busy === 1'b1, "R10 busy after start", 128'(chan_busy), 128'd1);
      run_xfer(VECS[v].base, int'(VECS[v].cnt), int'(VECS[v].mode),
               int'(VECS[v].cnt), "R1 table");
    end

    // R1: non-start value at the control offset
    cfg_write(8'h10, 32'h0000_0200);
    cfg_write(8'h20, 32'd2);
    cfg_write(8'h00, 32'h3);
    begin
      bit moved = 0;
      for (int i = 0; i < 8; i++) begin
        #1;
        if (chan_busy || mem_req || done_pulse || out_valid) moved = 1;
        @(negedge clk);
      end
      check(!moved, "R1 non-1 control value starts nothing", 128'(moved), 128'd0);
    end

    // R7: zero count
    cfg_write(8'h20, 32'd0);
    cfg_write(8'h00, 32'h1);
    #1;
    check(done_pulse && !chan_busy && !mem_req, "R7 zero count done at once",
          {done_pulse, chan_busy, mem_req}, 3'b100);
    @(negedge clk); #1;
    check(!done_pulse && !out_valid && !mem_req, "R7 zero count single pulse, no beat",
          {done_pulse, out_valid, mem_req}, 3'b000);

    // R8: writes while busy are ignored
    @(negedge clk);
    cfg_write(8'h10, 32'h0000_0700);
    cfg_write(8'h20, 32'd3);
    cfg_write(8'h00, 32'h1);
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    cfg_write(8'h10, 32'h0000_9990);
    cfg_write(8'h20, 32'd9);
    cfg_write(8'h00, 32'h1);
    run_xfer(32'h0000_0700, 3, 1, 2, "R8 writes while busy");

    // R9: reset mid-transfer
    cfg_write(8'h10, 32'h0000_0A00);
    cfg_write(8'h20, 32'd4);
    cfg_write(8'h00, 32'h1);
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk); #1;
    check(!chan_busy && !out_valid && !mem_req && !done_pulse, "R9 reset mid-transfer",
          {chan_busy, out_valid, mem_req, done_pulse}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // after reset a fresh transfer still runs (count register cleared, reload)
    cfg_write(8'h10, 32'h0000_0C40);
    cfg_write(8'h20, 32'd2);
    cfg_write(8'h00, 32'h1);
    run_xfer(32'h0000_0C40, 2, 2, 2, "R9 post-reset transfer");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule